// File: doc/BRIEF.md
# ADC Scan Control Sequencer

This block holds the 16-bit mode word of a multi-channel analog-to-digital converter and runs the sequence that feeds it. A processor writes the word as a full word, as either byte, or one bit at a time. The block then selects channels and issues one-cycle start pulses to an external converter, and it waits for a one-cycle done strobe before it goes on. The word chooses between two modes. Scan mode walks a channel window upward. Select mode repeats a single channel. The word also chooses what starts each pass: software (plain or polling), a timer pulse or an external pulse.

A read-only status bit in the word rises only after a settling window that follows each start. The window is timed by a clock-enable at half the core rate. Any write that lands while the sequencer is active throws the current work away, and the sequence starts again from its first channel.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the word reads 0x0000, and no start pulse is issued.
- R2: The word can be written by byte lanes (wrByteEn[1] for bits 15:8, wrByteEn[0] for bits 7:0) and by a single-bit write (bitWr, bitIdx, bitVal), which is applied on top of the byte lanes. Writes to bit 14 (status) have no effect, and bit 13 always reads 0. The other fields are: bit 15 enable, bit 12 mode (0 scan, 1 select), bits 11:8 trigger code, bits 7:4 first channel, bits 3:0 last channel.
- R3: When a write arrives while bit 15 already reads 1, the write leaves the trigger code unchanged. This also holds for a write that clears enable and changes the code together, and no start follows such a write.
- R4: With a trigger code other than 0000, 0001, 0111 or 1000, no start pulse is issued, even with enable set.
- R5: With code 0000 (software) or 1000 (software polling), a write that leaves the block enabled gives a start pulse two cycles after the write cycle.
- R6: With code 0001 (timer) or 0111 (external), each pass waits for a one-cycle trigIn pulse. The start comes in the cycle after the pulse, and trigIn pulses outside the wait are ignored.
- R7: In scan mode the channels run from the first channel up to the last channel, one per done strobe, and then wrap to the first. If first > last, only the last channel is converted. A done strobe gives the next start in the following cycle.
- R8: In select mode every start uses the last-channel field (bits 3:0).
- R9: The status bit reads 0 in the start cycle and for the 12 cycles after it (6 half-rate ticks), then reads 1 until the done strobe.
- R10: A write while the sequencer is active aborts the conversion, and the sequence restarts from the first channel.
- R11: After a write that clears enable, status reads 0 and no further start pulse is issued.
- R12: Each start pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrByteEn | input | 2 | Byte-lane write enables (bit 1 high byte, bit 0 low byte) |
| wrData | input | 16 | Write data for the byte lanes |
| bitWr | input | 1 | Single-bit write strobe |
| bitIdx | input | 4 | Bit position for a single-bit write |
| bitVal | input | 1 | Value for a single-bit write |
| trigIn | input | 1 | Timer or external trigger pulse |
| convDone | input | 1 | Converter done strobe |
| rdData | output | 16 | Mode word with live status in bit 14 |
| chanSel | output | 4 | Channel presented to the converter |
| convStart | output | 1 | One-cycle conversion start pulse |

## Verification
The assertions assume that the converter returns at most one done strobe for each start pulse, and that trigIn is a single-cycle pulse. The window rule also depends on the converter taking longer than the settling window. The bench converter answers every start with exactly one done strobe a fixed 20 cycles later, and a newer start replaces any answer still pending. The bench raises trigIn for one cycle only, while the block waits for a trigger or sits idle. Random writes keep to whole-word, byte and bit accesses. The status bit is masked out of those comparisons, because its value depends on when the conversions happen.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W = 4;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_LAUNCH,
    ST_CONV
  } seqState_t;

  typedef struct packed {
    logic loadFirst;
    logic stepChan;
    logic clrSettle;
    logic runSettle;
  } seqStrobes_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enBit,
  input  logic        modeSel,
  input  logic [3:0]  trigCode,
  input  logic        atLast,
  input  logic        writeEvt,
  input  logic        trigIn,
  input  logic        convDone,
  output seqStrobes_t strb,
  output logic        convStart
);
  seqState_t stateQ, stateNext;
  logic trigOk, swTrig, active;

  always_comb begin
    trigOk = 1'b0;
    swTrig = 1'b0;
    case (trigCode)
      4'b0000, 4'b1000: begin trigOk = 1'b1; swTrig = 1'b1; end
      4'b0001, 4'b0111: trigOk = 1'b1;
      default:          trigOk = 1'b0;
    endcase
  end

  assign active = enBit && trigOk;

  always_comb begin
    strb = '0;
    stateNext = stateQ;
    strb.runSettle = (stateQ == ST_CONV);
    if (writeEvt || !active) begin
      stateNext = ST_IDLE;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          strb.loadFirst = 1'b1;
          stateNext = swTrig ? ST_LAUNCH : ST_ARMED;
        end
        ST_ARMED: if (trigIn) stateNext = ST_LAUNCH;
        ST_LAUNCH: begin
          strb.clrSettle = 1'b1;
          stateNext = ST_CONV;
        end
        ST_CONV: if (convDone) begin
          if (!modeSel && !atLast) begin
            strb.stepChan = 1'b1;
            stateNext = ST_LAUNCH;
          end else begin
            strb.loadFirst = 1'b1;
            stateNext = swTrig ? ST_LAUNCH : ST_ARMED;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  assign convStart = (stateQ == ST_LAUNCH);
endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_TICKS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        wrByteEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              bitWr,
  input  logic [3:0]        bitIdx,
  input  logic              bitVal,
  input  seqStrobes_t       strb,
  output logic [WORD_W-1:0] rdData,
  output logic              enBit,
  output logic              modeSel,
  output logic [3:0]        trigCode,
  output logic [CH_W-1:0]   chanSel,
  output logic              atLast,
  output logic              writeEvt
);
  localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SETTLE_TICKS);

  logic              enQ, modeQ;
  logic [3:0]        trigQ;
  logic [CH_W-1:0]   firstQ, lastQ, chanQ, firstChan;
  logic [WORD_W-1:0] img;
  logic              phaseQ, statBit;
  logic [CNT_W-1:0]  settleQ;
  logic              unusedImg;

  assign writeEvt = (|wrByteEn) || bitWr;

  always_comb begin
    img = {enQ, 1'b0, 1'b0, modeQ, trigQ, firstQ, lastQ};
    if (wrByteEn[0]) img[7:0]  = wrData[7:0];
    if (wrByteEn[1]) img[15:8] = wrData[15:8];
    if (bitWr)       img[bitIdx] = bitVal;
  end
  assign unusedImg = &{1'b0, img[14:13]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= 1'b0; modeQ <= 1'b0; trigQ <= '0; firstQ <= '0; lastQ <= '0;
    end else if (writeEvt) begin
      enQ    <= img[15];
      modeQ  <= img[12];
      if (!enQ) trigQ <= img[11:8];
      firstQ <= img[7:4];
      lastQ  <= img[3:0];
    end
  end

  assign firstChan = (modeQ || (firstQ > lastQ)) ? lastQ : firstQ;
  assign atLast    = (chanQ >= lastQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              chanQ <= '0;
    else if (strb.loadFirst) chanQ <= firstChan;
    else if (strb.stepChan)  chanQ <= chanQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= 1'b0; settleQ <= '0;
    end else if (strb.clrSettle) begin
      phaseQ <= 1'b0; settleQ <= '0;
    end else if (strb.runSettle) begin
      phaseQ <= ~phaseQ;
      if (phaseQ && (settleQ < CNT_FULL)) settleQ <= settleQ + 1'b1;
    end
  end

  assign statBit  = strb.runSettle && (settleQ == CNT_FULL);
  assign rdData   = {enQ, statBit, 1'b0, modeQ, trigQ, firstQ, lastQ};
  assign enBit    = enQ;
  assign modeSel  = modeQ;
  assign trigCode = trigQ;
  assign chanSel  = chanQ;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_TICKS = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  wrByteEn,
  input  logic [15:0] wrData,
  input  logic        bitWr,
  input  logic [3:0]  bitIdx,
  input  logic        bitVal,
  input  logic        trigIn,
  input  logic        convDone,
  output logic [15:0] rdData,
  output logic [3:0]  chanSel,
  output logic        convStart
);
  seqStrobes_t strb;
  logic enBit, modeSel, atLast, writeEvt;
  logic [3:0] trigCode;

  adc_seq_datapath #(.SETTLE_TICKS(SETTLE_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .wrByteEn(wrByteEn), .wrData(wrData),
    .bitWr(bitWr), .bitIdx(bitIdx), .bitVal(bitVal), .strb(strb),
    .rdData(rdData), .enBit(enBit), .modeSel(modeSel), .trigCode(trigCode),
    .chanSel(chanSel), .atLast(atLast), .writeEvt(writeEvt)
  );

  adc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enBit(enBit), .modeSel(modeSel),
    .trigCode(trigCode), .atLast(atLast), .writeEvt(writeEvt),
    .trigIn(trigIn), .convDone(convDone), .strb(strb), .convStart(convStart)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int SETTLE_TICKS = 6
) (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] rdData,
  input logic [3:0]  chanSel,
  input logic        convStart
);
  localparam int WIN = 2 * SETTLE_TICKS + 1;
  logic [7:0] sinceStart;
  logic       codeOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceStart <= '0;
    else if (convStart)         sinceStart <= 8'd1;
    else if (sinceStart != '1)  sinceStart <= sinceStart + 8'd1;
  end

  always_comb begin
    codeOk = (rdData[11:8] == 4'b0000) || (rdData[11:8] == 4'b0001) ||
             (rdData[11:8] == 4'b0111) || (rdData[11:8] == 4'b1000);
  end

  // R2
  bit13_zero_chk: assert property (@(posedge clk) disable iff (!rstN) rdData[13] == 1'b0);
  // R3
  trig_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[15] |=> $stable(rdData[11:8]));
  // R4
  bad_code_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !codeOk |-> !convStart);
  // R7
  scan_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && !rdData[12]) |-> (chanSel <= rdData[3:0]));
  // R8
  select_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && rdData[12]) |-> (chanSel == rdData[3:0]));
  // R9
  status_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[14] |-> (!convStart && (int'(sinceStart) >= WIN)));
  // R11
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[15] |-> (!convStart && !rdData[14]));
  // R12
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.SETTLE_TICKS(SETTLE_TICKS)) u_chk (
  .clk(clk), .rstN(rstN), .rdData(rdData), .chanSel(chanSel), .convStart(convStart)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DONE_DLY = 20;
  localparam int STEP = DONE_DLY + 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] wrByteEn = '0;
  logic [15:0] wrData = '0;
  logic bitWr = 1'b0, bitVal = 1'b0, trigIn = 1'b0, convDone = 1'b0;
  logic [3:0] bitIdx = '0;
  logic [15:0] rdData;
  logic [3:0] chanSel;
  logic convStart;

  int cyc = 0, errors = 0, checks = 0, pend = 0, lastStart = -1;
  logic [15:0] regM = '0;

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rstN(rstN), .wrByteEn(wrByteEn), .wrData(wrData), .bitWr(bitWr),
    .bitIdx(bitIdx), .bitVal(bitVal), .trigIn(trigIn), .convDone(convDone),
    .rdData(rdData), .chanSel(chanSel), .convStart(convStart)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // converter model: one done strobe DONE_DLY cycles after each start
  always @(negedge clk) begin
    convDone = 1'b0;
    if (convStart) pend = DONE_DLY;
    else if (pend > 0) begin
      pend--;
      if (pend == 0) convDone = 1'b1;
    end
  end

  function automatic logic [15:0] applyW(logic [15:0] cur, logic [1:0] be, logic [15:0] d,
                                         logic bw, logic [3:0] idx, logic bv);
    logic [15:0] img, res;
    img = cur;
    if (be[0]) img[7:0] = d[7:0];
    if (be[1]) img[15:8] = d[15:8];
    if (bw) img[idx] = bv;
    res = img;
    res[14] = 1'b0;
    res[13] = 1'b0;
    if (cur[15]) res[11:8] = cur[11:8];
    return res;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] be, logic [15:0] d, logic bw, logic [3:0] idx,
                    logic bv, output int w);
    w = cyc;
    wrByteEn = be; wrData = d; bitWr = bw; bitIdx = idx; bitVal = bv;
    regM = applyW(regM, be, d, bw, idx, bv);
    @(negedge clk);
    wrByteEn = '0; bitWr = 1'b0;
  endtask

  task automatic wrWord(logic [15:0] d, output int w);
    wr(2'b11, d, 1'b0, 4'd0, 1'b0, w);
  endtask

  task automatic clearAll();
    int w;
    wrWord(16'h0000, w);
    wrWord(16'h0000, w);
  endtask

  task automatic expectStart(int expChan, int expCyc, string req, output int t);
    int n = 0;
    if (convStart && cyc == lastStart) @(negedge clk);
    while (!convStart && n < 300) begin @(negedge clk); n++; end
    t = cyc;
    lastStart = cyc;
    chk(convStart == 1'b1, req, "start seen", int'(convStart), 1);
    chk(chanSel == expChan[3:0], req, "channel", int'(chanSel), expChan);
    if (expCyc >= 0) chk(t == expCyc, req, "start cycle", t, expCyc);
  endtask

  task automatic noStart(int n, string req);
    int cnt = 0;
    repeat (n) begin @(negedge clk); if (convStart) cnt++; end
    chk(cnt == 0, req, "unexpected starts", cnt, 0);
  endtask

  task automatic pulseTrig(output int k);
    k = cyc;
    trigIn = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w, t, k;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(rdData == 16'h0000, "R1", "reset word", int'(rdData), 0);
    chk(convStart == 1'b0, "R1", "reset start", int'(convStart), 0);

    // R2 R3: random word/byte/bit writes against the model (status masked)
    for (int i = 0; i < 60; i++) begin
      logic [1:0] be;
      logic bw;
      be = 2'($urandom % 4);
      bw = 1'($urandom % 2);
      wr(be, 16'($urandom), bw, 4'($urandom % 16), 1'($urandom % 2), w);
      chk((rdData & 16'hBFFF) == regM, "R2", "random write readback",
          int'(rdData & 16'hBFFF), int'(regM));
    end
    clearAll();
    noStart(30, "R11");

    // R2 status bit and bit 13 not writable
    wr(2'b00, 16'h0, 1'b1, 4'd14, 1'b1, w);
    wr(2'b00, 16'h0, 1'b1, 4'd13, 1'b1, w);
    chk(rdData == 16'h0000, "R2", "bits 14/13 ignored", int'(rdData), 0);

    // R5 R9 R7 scan 2..5, software trigger
    wrWord(16'h8025, w);
    expectStart(2, w + 2, "R5", t);
    repeat (12) @(negedge clk);
    chk(rdData[14] == 1'b0, "R9", "status in window", int'(rdData[14]), 0);
    @(negedge clk);
    chk(rdData[14] == 1'b1, "R9", "status after window", int'(rdData[14]), 1);
    repeat (DONE_DLY - 13) @(negedge clk);
    chk(rdData[14] == 1'b1, "R9", "status at done", int'(rdData[14]), 1);
    expectStart(3, t + STEP, "R7", k);
    chk(rdData[14] == 1'b0, "R9", "status at restart", int'(rdData[14]), 0);
    expectStart(4, t + 2 * STEP, "R7", k);
    expectStart(5, t + 3 * STEP, "R7", k);
    expectStart(2, t + 4 * STEP, "R7 wrap", k);
    expectStart(3, t + 5 * STEP, "R7", k);

    // R10 write mid-conversion restarts from first channel
    repeat (5) @(negedge clk);
    wr(2'b01, 16'h0025, 1'b0, 4'd0, 1'b0, w);
    expectStart(2, w + 2, "R10", k);

    // R11 clear enable by bit write
    repeat (3) @(negedge clk);
    wr(2'b00, 16'h0, 1'b1, 4'd15, 1'b0, w);
    chk(rdData[15:14] == 2'b00, "R11", "enable/status off", int'(rdData[15:14]), 0);
    noStart(60, "R11");

    // R7 first > last converts last only
    clearAll();
    wrWord(16'h8052, w);
    expectStart(2, w + 2, "R7 first>last", t);
    expectStart(2, t + STEP, "R7 first>last", k);
    expectStart(2, t + 2 * STEP, "R7 first>last", k);

    // R8 select mode
    clearAll();
    wrWord(16'h9047, w);
    expectStart(7, w + 2, "R8", t);
    expectStart(7, t + STEP, "R8", k);
    expectStart(7, t + 2 * STEP, "R8", k);

    // R5 polling code; R3 combined clear + code change
    clearAll();
    wrWord(16'h8813, w);
    expectStart(1, w + 2, "R5 polling", t);
    wrWord(16'h0100, w);
    chk(rdData[11:8] == 4'b1000, "R3", "code kept", int'(rdData[11:8]), 8);
    chk(rdData[15] == 1'b0, "R3", "enable cleared", int'(rdData[15]), 0);
    noStart(40, "R3");

    // R4 prohibited code
    wrWord(16'h8300, w);
    chk(rdData[11:8] == 4'b0011, "R4", "code stored", int'(rdData[11:8]), 3);
    noStart(50, "R4");

    // R6 timer trigger, scan 1..3
    clearAll();
    wrWord(16'h8113, w);
    noStart(30, "R6 wait");
    pulseTrig(k);
    expectStart(1, k + 1, "R6", t);
    expectStart(2, t + STEP, "R6", k);
    expectStart(3, t + 2 * STEP, "R6", k);
    noStart(60, "R6 pass end");
    pulseTrig(k);
    expectStart(1, k + 1, "R6 next pass", t);

    // R6 external trigger, trigger pulse while idle ignored
    clearAll();
    pulseTrig(k);
    wrWord(16'h8723, w);
    noStart(20, "R6 idle pulse");
    pulseTrig(k);
    expectStart(2, k + 1, "R6 external", t);

    clearAll();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule